// File: doc/BRIEF.md
# Page Access Permission Checker with Reference/Change Update

This block decides whether one memory access may use a leaf page-table entry, and what rights the entry grants. It takes the entry, where the entry lives in memory, the access kind (load, store or fetch), whether the requester is in user state, whether the check belongs to the process stage or the partition stage of translation, and a 3-bit allow mask from the authority-mask register. It returns the permission set, a fault cause vector and the entry as it should now read. When the entry's reference or change bit had to be set, it also issues a write-back request.

Reference and change bits are kept up to date lazily. Every successful access sets the reference bit, and only a store sets the change bit. After a load or fetch, the returned permission set drops write. A later store therefore comes back through the checker and marks the page changed. Execute access to a non-idempotent I/O page fails as a guarded fault. A privileged-only page gives a user-state requester nothing in the process stage.

Requests arrive on a valid/ready port. The result leaves on a valid/ready response port, and the write-back leaves on its own valid/ready port. Each output holds its payload until it is accepted. A new request is taken only when neither output is still waiting. Each output drains independently of the other.

Top module: `pcc_top`

## Requirements
- R1: After reset `rsp_valid` and `wb_valid` are low and `req_ready` is high. A request accepted on a clock edge gives `rsp_valid` high in the following cycle.
- R2: Entry layout is fixed: read permission in bit 0, write in bit 1, execute in bit 2, privileged-only in bit 3, attribute in bits 5:4, reference in bit 6, change in bit 7. Access codes are 0 load, 1 store, 2 fetch. A fetch (code 2) to an entry whose attribute is 2'b10 (non-idempotent I/O) returns cause 3'b001 (guard), permission 3'b000, the entry unchanged, and no write-back.
- R3: In the process stage (`req_partition`=0), an entry with bit 3 set that is accessed in user state yields permission 3'b000.
- R4: In the process stage, a supervisor access to an entry with bit 3 clear yields the entry's bits 2:0 ANDed with `req_amr`.
- R5: In every other case, the permission is the entry's bits 2:0 alone. This covers user access to a normal entry, supervisor access to a privileged entry, and any check in the partition stage.
- R6: If the permission needed by the access is missing, cause bit 1 (protection) is set. The entry is returned unchanged and no write-back is issued. The returned permission is the computed set.
- R7: A store that faults also sets cause bit 2 (is-store). No other fault sets it.
- R8: On success the returned entry has bit 6 set, and bit 7 set when the access is a store. All other bits are unchanged.
- R9: On a successful load or fetch, the returned permission has write (bit 1) cleared. On a successful store it is the full computed set.
- R10: A write-back is issued only on success and only when the updated entry differs from the original. It carries the request's entry address and the updated entry.
- R11: Access code 3 is checked exactly as a load.
- R12: While `rsp_valid` or `wb_valid` is high, `req_ready` is low and no request is taken. Each output keeps its payload stable until its own ready is seen. The two outputs drain independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Check request present |
| req_ready | output | 1 | Block can take a request |
| req_pte | input | PTE_W | Leaf entry to check |
| req_pte_addr | input | ADDR_W | Memory address of the entry |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| req_user | input | 1 | Requester is in user state |
| req_partition | input | 1 | Check belongs to the partition stage |
| req_amr | input | 3 | Allow mask {exec, write, read} from authority-mask register |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_perm | output | 3 | Permission set {exec, write, read} |
| rsp_fault | output | 1 | Any cause bit set |
| rsp_cause | output | 3 | Cause {is-store, protection, guard} |
| rsp_pte | output | PTE_W | Entry after reference/change update |
| wb_valid | output | 1 | Write-back request present |
| wb_ready | input | 1 | Memory side accepts the write-back |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | PTE_W | Write-back data |

## Verification
The response and the write-back are produced by the same request, so both outputs become valid in the same cycle. They can be accepted in the same cycle or in different cycles. The table-driven part keeps both readies high, so both outputs are consumed on one edge, and it checks that the checker is free again on the next cycle. A directed test then holds both readies low while a different request waits at the input. It releases the write-back first and the response later. At each step it checks that each payload stays unchanged, that `req_ready` stays low until both outputs have drained, and that the waiting request is never taken.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  // Access kinds
  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  // Permission vector bit positions {exec, write, read}
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;
  localparam int PERM_N  = 3;

  // Cause vector bit positions
  localparam int CAUSE_GUARD = 0;
  localparam int CAUSE_PROT  = 1;
  localparam int CAUSE_STORE = 2;
  localparam int CAUSE_N     = 3;

  // Leaf entry field positions
  localparam int ENT_ACC_LSB  = 0;
  localparam int ENT_PRIV     = 3;
  localparam int ENT_ATTR_LSB = 4;
  localparam int ENT_REF      = 6;
  localparam int ENT_CHG      = 7;
  localparam logic [1:0] ATTR_NONIDEM_IO = 2'b10;
endpackage

// File: rtl/pcc_perm_eval.sv
module pcc_perm_eval
  import pcc_pkg::*;
(
  input  logic [PERM_N-1:0]  ent_acc,
  input  logic               ent_priv,
  input  logic [1:0]         ent_attr,
  input  logic [1:0]         acc,
  input  logic               user,
  input  logic               partition,
  input  logic [PERM_N-1:0]  amr,
  output logic [PERM_N-1:0]  perm,
  output logic [CAUSE_N-1:0] cause
);
  logic              is_fetch, is_store, guard_hit;
  logic [PERM_N-1:0] need;
  logic [PERM_N-1:0] granted;

  assign is_fetch  = (acc == ACC_FETCH);
  assign is_store  = (acc == ACC_STORE);
  assign guard_hit = is_fetch && (ent_attr == ATTR_NONIDEM_IO);

  // One-hot need vector; code 3 falls to the load case
  always_comb begin
    need = '0;
    unique case (acc)
      ACC_STORE: need[PERM_WR] = 1'b1;
      ACC_FETCH: need[PERM_EX] = 1'b1;
      default:   need[PERM_RD] = 1'b1;
    endcase
  end

  // Permission selection per stage and privilege
  always_comb begin
    if (!partition && ent_priv && user)
      granted = '0;
    else if (!partition && !ent_priv && !user)
      granted = ent_acc & amr;
    else
      granted = ent_acc;
  end

  logic [PERM_N-1:0] miss;
  for (genvar b = 0; b < PERM_N; b++) begin : g_miss
    assign miss[b] = need[b] & ~granted[b];
  end

  always_comb begin
    cause = '0;
    perm  = granted;
    if (guard_hit) begin
      cause[CAUSE_GUARD] = 1'b1;
      perm               = '0;
    end else if (|miss) begin
      cause[CAUSE_PROT]  = 1'b1;
      cause[CAUSE_STORE] = is_store;
    end
  end
endmodule

// File: rtl/pcc_rc_update.sv
module pcc_rc_update
  import pcc_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0]  ent_in,
  input  logic [1:0]        acc,
  input  logic              ok,
  input  logic [PERM_N-1:0] perm_in,
  output logic [PTE_W-1:0]  ent_out,
  output logic              changed,
  output logic [PERM_N-1:0] perm_out
);
  logic is_store;
  assign is_store = (acc == ACC_STORE);

  always_comb begin
    ent_out  = ent_in;
    perm_out = perm_in;
    if (ok) begin
      ent_out[ENT_REF] = 1'b1;
      if (is_store) ent_out[ENT_CHG] = 1'b1;
      else          perm_out[PERM_WR] = 1'b0;
    end
  end

  assign changed = ok && (ent_out != ent_in);
endmodule

// File: rtl/pcc_hold_slot.sv
module pcc_hold_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R12: a waiting payload does not move
  p_hold_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(dout));
  // R12: nothing loads over a waiting payload
  p_no_overwrite_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid);
endmodule

// File: rtl/pcc_top.sv
module pcc_top
  import pcc_pkg::*;
#(
  parameter int PTE_W  = 64,
  parameter int ADDR_W = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PTE_W-1:0]  req_pte,
  input  logic [ADDR_W-1:0] req_pte_addr,
  input  logic [1:0]        req_acc,
  input  logic              req_user,
  input  logic              req_partition,
  input  logic [2:0]        req_amr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_perm,
  output logic              rsp_fault,
  output logic [2:0]        rsp_cause,
  output logic [PTE_W-1:0]  rsp_pte,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [PTE_W-1:0]  wb_data
);
  localparam int RSP_W = PTE_W + CAUSE_N + PERM_N;
  localparam int WB_W  = ADDR_W + PTE_W;

  logic              fire;
  logic [PERM_N-1:0] perm_raw, perm_fin;
  logic [CAUSE_N-1:0] cause;
  logic [PTE_W-1:0]  ent_new;
  logic              changed, ok;
  logic [RSP_W-1:0]  rsp_bus;
  logic [WB_W-1:0]   wb_bus;

  assign req_ready = !rsp_valid && !wb_valid;
  assign fire      = req_valid && req_ready;

  pcc_perm_eval u_eval (
    .ent_acc   (req_pte[ENT_ACC_LSB +: PERM_N]),
    .ent_priv  (req_pte[ENT_PRIV]),
    .ent_attr  (req_pte[ENT_ATTR_LSB +: 2]),
    .acc       (req_acc),
    .user      (req_user),
    .partition (req_partition),
    .amr       (req_amr),
    .perm      (perm_raw),
    .cause     (cause)
  );

  assign ok = (cause == '0);

  pcc_rc_update #(.PTE_W(PTE_W)) u_rc (
    .ent_in   (req_pte),
    .acc      (req_acc),
    .ok       (ok),
    .perm_in  (perm_raw),
    .ent_out  (ent_new),
    .changed  (changed),
    .perm_out (perm_fin)
  );

  pcc_hold_slot #(.W(RSP_W)) u_rsp (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire),
    .din   ({ent_new, cause, perm_fin}),
    .valid (rsp_valid),
    .ready (rsp_ready),
    .dout  (rsp_bus)
  );

  pcc_hold_slot #(.W(WB_W)) u_wb (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire && changed),
    .din   ({req_pte_addr, ent_new}),
    .valid (wb_valid),
    .ready (wb_ready),
    .dout  (wb_bus)
  );

  assign rsp_perm  = rsp_bus[PERM_N-1:0];
  assign rsp_cause = rsp_bus[PERM_N +: CAUSE_N];
  assign rsp_pte   = rsp_bus[RSP_W-1 -: PTE_W];
  assign rsp_fault = |rsp_cause;
  assign wb_data   = wb_bus[PTE_W-1:0];
  assign wb_addr   = wb_bus[WB_W-1 -: ADDR_W];

  // R1: an accepted request shows a result next cycle
  p_fire_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
  // R10: write-back appears only beside a successful result
  p_wb_success_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> rsp_valid && !rsp_fault);
  // R10: both slots hold the same updated entry while both wait
  p_wb_matches_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && rsp_valid |-> wb_data == rsp_pte);
  // R8: a successful result always carries the reference bit
  p_ref_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_pte[ENT_REF]);
  // R2: guard fault stands alone with no permissions
  p_guard_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_cause[CAUSE_GUARD] |-> rsp_perm == '0 && $countones(rsp_cause) == 1);
  // R7: is-store never appears without a protection fault
  p_store_with_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_cause[CAUSE_STORE] |-> rsp_cause[CAUSE_PROT]);
endmodule

// File: tb/pcc_top_test.sv
module pcc_top_test;
  localparam int PTE_W  = 64;
  localparam int ADDR_W = 52;
  localparam logic [55:0] HI = 56'h5A_C3F0_1E2D_3C4B;

  typedef struct packed {
    logic [7:0] pte;
    logic [1:0] acc;
    logic       user;
    logic       part;
    logic [2:0] amr;
    logic [2:0] eperm;
    logic [2:0] ecause;
    logic       ewb;
    logic [7:0] epte;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{8'h07, 2'd0, 1'b0, 1'b0, 3'd7, 3'd5, 3'd0, 1'b1, 8'h47}, // R4 R8 R9 R10 load
    '{8'h07, 2'd1, 1'b0, 1'b0, 3'd7, 3'd7, 3'd0, 1'b1, 8'hC7}, // R8 R9 store sets change
    '{8'hC7, 2'd1, 1'b0, 1'b0, 3'd7, 3'd7, 3'd0, 1'b0, 8'hC7}, // R10 unchanged no wb
    '{8'h47, 2'd0, 1'b0, 1'b0, 3'd7, 3'd5, 3'd0, 1'b0, 8'h47}, // R10 ref already set
    '{8'h27, 2'd2, 1'b0, 1'b0, 3'd7, 3'd0, 3'd1, 1'b0, 8'h27}, // R2 guard fetch
    '{8'h27, 2'd0, 1'b0, 1'b0, 3'd7, 3'd5, 3'd0, 1'b1, 8'h67}, // R2 load to io ok
    '{8'h0F, 2'd0, 1'b1, 1'b0, 3'd7, 3'd0, 3'd2, 1'b0, 8'h0F}, // R3 R6 user priv load
    '{8'h0F, 2'd1, 1'b1, 1'b0, 3'd7, 3'd0, 3'd6, 1'b0, 8'h0F}, // R3 R7 user priv store
    '{8'h07, 2'd1, 1'b0, 1'b0, 3'd1, 3'd1, 3'd6, 1'b0, 8'h07}, // R4 R7 amr blocks write
    '{8'h07, 2'd0, 1'b0, 1'b0, 3'd1, 3'd1, 3'd0, 1'b1, 8'h47}, // R4 amr read ok
    '{8'h0F, 2'd0, 1'b1, 1'b1, 3'd0, 3'd5, 3'd0, 1'b1, 8'h4F}, // R5 partition stage
    '{8'h0B, 2'd2, 1'b0, 1'b0, 3'd0, 3'd3, 3'd2, 1'b0, 8'h0B}, // R5 R6 sup priv no exec
    '{8'h03, 2'd1, 1'b1, 1'b0, 3'd0, 3'd3, 3'd0, 1'b1, 8'hC3}, // R5 user normal store
    '{8'h01, 2'd3, 1'b0, 1'b1, 3'd0, 3'd1, 3'd0, 1'b1, 8'h41}, // R11 code 3 as load
    '{8'h37, 2'd2, 1'b0, 1'b0, 3'd7, 3'd5, 3'd0, 1'b1, 8'h77}, // R2 R9 other attr fetch
    '{8'h27, 2'd1, 1'b0, 1'b0, 3'd7, 3'd7, 3'd0, 1'b1, 8'hE7}  // R8 store to io
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [PTE_W-1:0] req_pte = '0;
  logic [ADDR_W-1:0] req_pte_addr = '0;
  logic [1:0] req_acc = '0;
  logic req_user = 1'b0, req_partition = 1'b0;
  logic [2:0] req_amr = '0;
  logic rsp_valid, rsp_fault, wb_valid;
  logic rsp_ready = 1'b1, wb_ready = 1'b1;
  logic [2:0] rsp_perm, rsp_cause;
  logic [PTE_W-1:0] rsp_pte, wb_data;
  logic [ADDR_W-1:0] wb_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcc_top #(.PTE_W(PTE_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_pte(req_pte), .req_pte_addr(req_pte_addr), .req_acc(req_acc),
    .req_user(req_user), .req_partition(req_partition), .req_amr(req_amr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_perm(rsp_perm),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_pte(rsp_pte),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic [ADDR_W-1:0] a);
    req_pte       = {HI, v.pte};
    req_pte_addr  = a;
    req_acc       = v.acc;
    req_user      = v.user;
    req_partition = v.part;
    req_amr       = v.amr;
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R1 wb_valid after reset", 64'(wb_valid), 64'd0);
    check("R1 req_ready after reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk, both readies high: both outputs drain on the same edge
    for (int i = 0; i < NV; i++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'(52'h0_1000_0000 + i * 8);
      drive(VEC[i], a);
      req_valid = 1'b1;
      check($sformatf("R12 vec%0d req_ready idle", i), 64'(req_ready), 64'd1);
      @(negedge clk);
      req_valid = 1'b0;
      check($sformatf("R1 vec%0d rsp_valid", i), 64'(rsp_valid), 64'd1);
      check($sformatf("R3 R4 R5 R9 vec%0d perm", i), 64'(rsp_perm), 64'(VEC[i].eperm));
      check($sformatf("R2 R6 R7 vec%0d cause", i), 64'(rsp_cause), 64'(VEC[i].ecause));
      check($sformatf("R6 vec%0d fault flag", i), 64'(rsp_fault), 64'(VEC[i].ecause != 3'd0));
      check($sformatf("R8 vec%0d entry", i), rsp_pte, {HI, VEC[i].epte});
      check($sformatf("R10 vec%0d wb_valid", i), 64'(wb_valid), 64'(VEC[i].ewb));
      if (VEC[i].ewb) begin
        check($sformatf("R10 vec%0d wb_addr", i), 64'(wb_addr), 64'(a));
        check($sformatf("R10 vec%0d wb_data", i), wb_data, {HI, VEC[i].epte});
      end
      @(negedge clk);
      check($sformatf("R12 vec%0d drained rsp", i), 64'(rsp_valid), 64'd0);
      check($sformatf("R12 vec%0d drained wb", i), 64'(wb_valid), 64'd0);
    end

    // R12 back-pressure: stall both, offer another request meanwhile
    rsp_ready = 1'b0;
    wb_ready  = 1'b0;
    drive(VEC[0], 52'h0_2222_0000);
    req_valid = 1'b1;
    @(negedge clk);
    drive(VEC[6], 52'h0_3333_0000);
    for (int k = 0; k < 3; k++) begin
      check("R12 stall req_ready low", 64'(req_ready), 64'd0);
      check("R12 stall rsp held", rsp_pte, {HI, 8'h47});
      check("R12 stall rsp_valid", 64'(rsp_valid), 64'd1);
      check("R12 stall wb held", wb_data, {HI, 8'h47});
      check("R12 stall wb addr", 64'(wb_addr), 64'(52'h0_2222_0000));
      @(negedge clk);
    end
    req_valid = 1'b0;
    wb_ready  = 1'b1;
    @(negedge clk);
    wb_ready  = 1'b0;
    check("R12 wb drained alone", 64'(wb_valid), 64'd0);
    check("R12 rsp still waiting", 64'(rsp_valid), 64'd1);
    check("R12 rsp perm unchanged", 64'(rsp_perm), 64'd5);
    check("R12 req_ready low with rsp", 64'(req_ready), 64'd0);
    @(negedge clk);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R12 rsp drained", 64'(rsp_valid), 64'd0);
    check("R12 ready again", 64'(req_ready), 64'd1);
    @(negedge clk);
    check("R12 stalled request never taken", 64'(rsp_valid), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule